// File: doc/BRIEF.md
# Paired I/Q Sample FIFO with Almost-Empty Threshold

This block buffers transmit samples for one channel in two matched FIFOs, one for the in-phase (I) word and one for the quadrature (Q) word. A parallel source writes an I/Q pair in one cycle. The channel datapath pulls pairs with a read strobe. Both FIFOs share one write pointer and one read pointer, so they always hold the same number of pairs.

Storage sits at addresses 1 to 8. Address 0 is never written and always reads as zero. When the FIFO is empty or the channel is offline, the read address parks on 0, so the datapath sees zero data. A single 3-bit threshold, coded as fill level minus one, drives an almost-empty flag that tells the source to send more data. A write into a full FIFO is dropped and reported as overflow. In parallel input mode, an overflow also resets the channel unless that reset is disabled.

Top module: `iq_fifo_pair`

## Requirements
- R1: After reset the FIFO is empty, `almost_empty` is 1, `overflow` and `chan_reset` are 0, and `rd_i`/`rd_q` are 0.
- R2: Pairs leave in the order they were written. The oldest pair is shown on `rd_i`/`rd_q` in the cycle after it is written, or after the previous pair is popped by `rd_en`. I and Q of a pair always stay together.
- R3: The FIFO holds eight pairs. Eight writes into an empty FIFO are all accepted.
- R4: `almost_empty` is registered. After each clock edge it equals (fill level <= `ae_thr` + 1), using the new fill level and the threshold present before that edge. The one threshold serves both I and Q.
- R5: A read while the FIFO is empty returns zero data and moves no pointer. The next pair written is still the next pair read.
- R6: A write while the FIFO is full and not being read is dropped, and `overflow` is 1 for the cycle after it. Without a channel reset, the stored pairs are kept.
- R7: When a write is dropped with `par_mode`=1 and `ovf_rst_dis`=0, `chan_reset` is 1 in the same cycle as `overflow`, and the FIFO is emptied at that edge. In every other case `chan_reset` stays 0 and nothing is cleared.
- R8: While `online`=0 the fill level is forced to 0, both pointers return to address 1, writes are ignored and the outputs read zero. Going back online starts from an empty FIFO.
- R9: A write and a read in the same cycle on a full FIFO both take effect. No overflow is raised and the fill level stays at eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online | input | 1 | 1 = normal operation, 0 = hold the FIFO empty and read zeros |
| par_mode | input | 1 | 1 = parallel input mode, where overflow may reset the channel |
| ovf_rst_dis | input | 1 | 1 = an overflow does not reset the channel |
| ae_thr | input | 3 | Almost-empty threshold, coded as fill level minus one |
| wr_en | input | 1 | Write strobe for one I/Q pair |
| wr_i | input | 16 | I sample to write |
| wr_q | input | 16 | Q sample to write |
| rd_en | input | 1 | Pop the pair shown at the outputs |
| rd_i | output | 16 | Oldest I sample, or 0 when empty or offline |
| rd_q | output | 16 | Oldest Q sample, or 0 when empty or offline |
| almost_empty | output | 1 | Registered almost-empty flag |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| chan_reset | output | 1 | One-cycle channel-reset pulse caused by an overflow |

## Verification
The read data follows the pointers and the fill level combinationally, so a pair written or popped at one edge appears at the outputs before the next edge. `almost_empty`, `overflow` and `chan_reset` are registered from that same edge's fill update, so they are also due one edge after the stimulus. The bench drives on the falling edge, steps its own model once per rising edge, and compares every output at the following falling edge. Every result is therefore checked in the single cycle where it first becomes valid.

// File: rtl/iq_fifo_pair.sv
module iq_fifo_pair #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          online,
  input  logic          par_mode,
  input  logic          ovf_rst_dis,
  input  logic [TW-1:0] ae_thr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_i,
  input  logic [DW-1:0] wr_q,
  input  logic          rd_en,
  output logic [DW-1:0] rd_i,
  output logic [DW-1:0] rd_q,
  output logic          almost_empty,
  output logic          overflow,
  output logic          chan_reset
);
  localparam int AW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] FIRST = AW'(1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH);

  logic [DW-1:0] mem_i [1:DEPTH];
  logic [DW-1:0] mem_q [1:DEPTH];
  logic [AW-1:0] wptr, rptr, cnt, cnt_nxt, rd_addr;

  wire pop    = online && rd_en && (cnt != '0);
  wire push   = online && wr_en && ((cnt != LAST) || pop);
  wire drop   = online && wr_en && !push;
  wire do_rst = drop && par_mode && !ovf_rst_dis;
  wire clear  = !online || do_rst;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == LAST) ? FIRST : p + FIRST;
  endfunction

  always_comb begin
    if (clear) cnt_nxt = '0;
    else       cnt_nxt = cnt + AW'(push) - AW'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr         <= FIRST;
      rptr         <= FIRST;
      cnt          <= '0;
      almost_empty <= 1'b1;
      overflow     <= 1'b0;
      chan_reset   <= 1'b0;
    end else begin
      if (clear) begin
        wptr <= FIRST;
        rptr <= FIRST;
      end else begin
        if (push) wptr <= adv(wptr);
        if (pop)  rptr <= adv(rptr);
      end
      cnt          <= cnt_nxt;
      almost_empty <= (32'(cnt_nxt) <= 32'(ae_thr) + 32'd1);
      overflow     <= drop;
      chan_reset   <= do_rst;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_i[wptr] <= wr_i;
      mem_q[wptr] <= wr_q;
    end
  end

  assign rd_addr = (cnt == '0) ? '0 : rptr;
  assign rd_i    = (rd_addr == '0) ? '0 : mem_i[rd_addr];
  assign rd_q    = (rd_addr == '0) ? '0 : mem_q[rd_addr];

  AST_OFFLINE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !online |=> (cnt == '0 && rd_i == '0 && rd_q == '0)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (online && wr_en && !rd_en && cnt == LAST) |=> overflow); // R6
  AST_RESET_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |-> (overflow && cnt == '0)); // R7
  AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_rst_dis || !par_mode) |=> !chan_reset); // R7
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (online && rd_en && !wr_en && cnt == '0) |=> ($stable(rptr) && cnt == '0)); // R5
  AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (online && wr_en && rd_en && cnt == LAST) |=> (!overflow && cnt == LAST)); // R9
endmodule

// File: tb/iq_fifo_pair_tb_top.sv
module iq_fifo_pair_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, online = 1'b1, par_mode = 1'b1, ovf_rst_dis = 1'b0;
  logic [2:0] ae_thr = 3'd3;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_i = '0, wr_q = '0;
  logic [15:0] rd_i, rd_q;
  logic almost_empty, overflow, chan_reset;

  int n_chk = 0, n_err = 0;
  logic [15:0] mi [8];
  logic [15:0] mq [8];
  int  mcnt = 0;
  bit  m_ae = 1'b1, m_ovf = 1'b0, m_crst = 1'b0;

  always #10 clk = ~clk;

  iq_fifo_pair dut_i (.clk(clk), .rst_n(rst_n), .online(online), .par_mode(par_mode),
    .ovf_rst_dis(ovf_rst_dis), .ae_thr(ae_thr), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
    .rd_en(rd_en), .rd_i(rd_i), .rd_q(rd_q), .almost_empty(almost_empty),
    .overflow(overflow), .chan_reset(chan_reset));

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_ae(int c, logic [2:0] t);
    return c <= int'(t) + 1;
  endfunction

  task automatic step(bit w, logic [15:0] di, logic [15:0] dq, bit r, string dtag);
    bit pop, push, drop;
    wr_en = w; wr_i = di; wr_q = dq; rd_en = r;
    pop  = online && r && mcnt > 0;
    push = online && w && (mcnt < 8 || pop);
    drop = online && w && !push;
    if (pop) begin
      for (int k = 0; k < 7; k++) begin mi[k] = mi[k+1]; mq[k] = mq[k+1]; end
      mcnt--;
    end
    if (push) begin mi[mcnt] = di; mq[mcnt] = dq; mcnt++; end
    m_ovf  = drop;
    m_crst = drop && par_mode && !ovf_rst_dis;
    if (!online || m_crst) mcnt = 0;
    m_ae = exp_ae(mcnt, ae_thr);
    @(posedge clk);
    @(negedge clk);
    chk(dtag, "rd_i", rd_i, mcnt > 0 ? mi[0] : 16'h0);
    chk(dtag, "rd_q", rd_q, mcnt > 0 ? mq[0] : 16'h0);
    chk("R4", "almost_empty", almost_empty, m_ae);
    chk("R6", "overflow", overflow, m_ovf);
    chk("R7", "chan_reset", chan_reset, m_crst);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_i", rd_i, 0);
    chk("R1", "rd_q", rd_q, 0);
    chk("R1", "almost_empty", almost_empty, 1);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "chan_reset", chan_reset, 0);

    step(0, 0, 0, 1, "R5");
    step(1, 16'h1111, 16'hA111, 0, "R5");
    step(0, 0, 0, 1, "R2");
    for (int k = 0; k < 8; k++) step(1, 16'h0100 + 16'(k), 16'hB100 + 16'(k), 0, "R3");
    chk("R3", "full eight", rd_i, 16'h0100);
    step(1, 16'h0200, 16'hB200, 1, "R9");
    chk("R9", "overflow", overflow, 0);

    ovf_rst_dis = 1'b1;
    step(1, 16'hDEAD, 16'hBEEF, 0, "R6");
    chk("R6", "overflow", overflow, 1);
    ovf_rst_dis = 1'b0; par_mode = 1'b0;
    step(1, 16'hDEAD, 16'hBEEF, 0, "R7");
    chk("R7", "no reset serial", chan_reset, 0);
    par_mode = 1'b1;
    step(1, 16'hDEAD, 16'hBEEF, 0, "R7");
    chk("R7", "reset pulse", chan_reset, 1);
    chk("R7", "emptied", rd_i, 0);

    for (int k = 0; k < 3; k++) step(1, 16'h0300 + 16'(k), 16'hC300 + 16'(k), 0, "R2");
    online = 1'b0;
    step(0, 0, 0, 0, "R8");
    step(1, 16'h7777, 16'h7777, 0, "R8");
    online = 1'b1;
    step(0, 0, 0, 0, "R8");
    step(1, 16'h0400, 16'hC400, 0, "R8");
    chk("R8", "restart", rd_i, 16'h0400);

    for (int t = 0; t < 8; t++) begin
      ae_thr = 3'(t);
      step(0, 0, 0, 0, "R4");
    end

    for (int n = 0; n < 6000; n++) begin
      if (n % 97 == 0) ae_thr = 3'($urandom % 8);
      if (n % 211 == 0) begin par_mode = 1'($urandom); ovf_rst_dis = 1'($urandom); end
      online = ($urandom % 60) != 0;
      step(($urandom % 10) < 6, 16'($urandom), 16'($urandom), ($urandom % 10) < 5, "R2");
    end
    finish_run();
  end
endmodule